// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Control Registers

This block controls sixteen general-purpose pins through a small register file reached over a synchronous 32-bit read/write port. Every per-pin control register is changed with a split encoding: the low half of the write data names pins to set, and the high half names pins to clear. Software can therefore change one pin, or any group of pins, in a single write without reading the register first.

Six control registers hold, per pin, the driven level, the driver enable, the input enable, two output alternate-function selects and one input alternate-function select. The driven level and the driver enable leave the block as pin vectors. The input pins pass through a two-stage synchronizer. The synchronized level can be read back, and rising and falling transitions are latched into two sticky flag registers while the pin's input enable is set. Software clears a flag by writing a one to its bit. A separate read-back register returns the driven output level, so software can see what it is driving.

Typical use: to make pin n an output, set its input enable and driver enable, then set or clear its level. To make it an input, set its input enable and clear its driver enable. To claim it for plain use, clear its three alternate-function selects.

Top module: `gpio_bank_sc`

## Requirements
- R1: A write to a control register sets pin n's bit when write data bit n (0..15) is 1.
- R2: A write to a control register clears pin n's bit when write data bit n+16 is 1.
- R3: Bits whose set and clear bits are both 0 in a write keep their previous value.
- R4: When one write both sets and clears the same pin, the pin ends up cleared.
- R5: A read returns the register's 16 per-pin bits in bits 15..0, and bits 31..16 of every read are zero. Read data appears on `rd_data` in the cycle after the clock edge that sampled `rd_en`. Byte offsets: 0x00 level, 0x04 driver enable, 0x08 input enable, 0x0C output alternate A, 0x10 output alternate B, 0x14 input alternate, 0x18 read-back, 0x1C input sample, 0x20 rising flags, 0x24 falling flags.
- R6: `pin_out` equals the level register and `pin_oe` equals the driver-enable register. The read-back register (0x18) returns the level register.
- R7: The input sample register (0x1C) returns `pin_in` delayed by a two-flop synchronizer. A change on `pin_in` is not visible to a read sampled at the next clock edge, and it is visible three cycles later.
- R8: A 0-to-1 transition on a synchronized input sets that pin's rising flag (0x20) only while its input enable bit is 1.
- R9: A 1-to-0 transition on a synchronized input sets that pin's falling flag (0x24) only while its input enable bit is 1.
- R10: Writing a 1 to bit n (0..15) of a flag register clears that flag. Zero bits and bits 31..16 of the write have no effect. A new edge in the same cycle as its clear wins.
- R11: Reads of unmapped or non-word-aligned offsets return zero. Writes to them, and writes to the read-back and input sample registers, change no state.
- R12: Reset (synchronous, active high) clears every control register and flag, so `pin_out`, `pin_oe` and all reads are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write data (set half low, clear half high) |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin input levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin driver enable |

## Verification
The bench writes the same pin with set and clear in one word, to catch a design that lets the set win or that combines the halves wrongly. It writes the clear half with the set half at zero, to catch read-modify-write bugs that wipe unselected pins. It writes the flag registers with only the high half set, and with zero bits next to a one bit, to catch a design that applies the control-register encoding to the flags or clears too many flags. It changes inputs on pins whose input enable is off, and reads the sample register one edge after a change, to catch flags that latch on disabled pins and a synchronizer that is too shallow. It also writes to misaligned offsets, unmapped offsets and read-only registers, to catch decoders that alias them onto live registers.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int NPIN   = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NCTRL  = 6;

    // word index of each register (byte offset / 4)
    typedef enum logic [ADDR_W-3:0] {
        RI_LEVEL  = 6'd0,
        RI_DRV_EN = 6'd1,
        RI_IN_EN  = 6'd2,
        RI_OALT_A = 6'd3,
        RI_OALT_B = 6'd4,
        RI_IALT   = 6'd5,
        RI_RDBACK = 6'd6,
        RI_SAMPLE = 6'd7,
        RI_RISE   = 6'd8,
        RI_FALL   = 6'd9
    } reg_idx_e;

    typedef struct packed {
        logic [NPIN-1:0] clr;
        logic [NPIN-1:0] set;
    } setclr_t;

    typedef struct packed {
        logic              word_ok;
        logic [ADDR_W-3:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.word_ok = (a[1:0] == 2'b00);
        d.idx     = a[ADDR_W-1:2];
        return d;
    endfunction

    function automatic logic [NPIN-1:0] apply_setclr(input logic [NPIN-1:0] cur,
                                                     input setclr_t        sc);
        return (cur | sc.set) & ~sc.clr;
    endfunction

endpackage

// File: rtl/gpb_setclr_reg.sv
module gpb_setclr_reg
    import gpb_pkg::*;
#(
    parameter int W = NPIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_hit) begin
            q <= (q | set_bits) & ~clr_bits;
        end
    end

    // R2 / R4: any bit named in the clear half is zero after the write
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> ((q & $past(clr_bits)) == '0));

    // R3: bits not named in either half are untouched
    a_r3_keep_unnamed: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (((q ^ $past(q)) & ~($past(set_bits) | $past(clr_bits))) == '0));

    // R11: without a hit the register does not move
    a_r11_no_hit_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(q));

endmodule

// File: rtl/gpb_edge_unit.sv
module gpb_edge_unit
    import gpb_pkg::*;
#(
    parameter int W = NPIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] rise_clr,
    input  logic [W-1:0] fall_clr,
    output logic [W-1:0] sample_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] sync1, sync2, prev;
    logic [W-1:0] rise_det, fall_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pin_i;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise_det = sync2 & ~prev & en_i;
    assign fall_det = ~sync2 & prev & en_i;
    assign sample_o = sync2;

    // flag registers: a fresh edge outranks a clear in the same cycle
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_o[g] <= 1'b0;
                    fall_o[g] <= 1'b0;
                end else begin
                    rise_o[g] <= rise_det[g] | (rise_o[g] & ~rise_clr[g]);
                    fall_o[g] <= fall_det[g] | (fall_o[g] & ~fall_clr[g]);
                end
            end
        end
    endgenerate

    // R8: a rising flag only appears for an enabled pin
    a_r8_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_o & ~$past(rise_o) & ~$past(en_i)) == '0));

    // R9: a falling flag only appears for an enabled pin
    a_r9_fall_needs_en: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall_o & ~$past(fall_o) & ~$past(en_i)) == '0));

    // R10: flags only drop where a clear was requested
    a_r10_only_cleared_drop: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rise_o) & ~rise_o & ~$past(rise_clr)) == '0 &&
                  ($past(fall_o) & ~fall_o & ~$past(fall_clr)) == '0));

endmodule

// File: rtl/gpio_bank_sc.sv
module gpio_bank_sc
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);

    localparam int HALF = DATA_W / 2;

    dec_t            dec;
    setclr_t         wsc;
    logic [NPIN-1:0] ctrl_q [NCTRL];
    logic [NPIN-1:0] sample, rise_f, fall_f;
    logic [NPIN-1:0] rise_clr, fall_clr;
    logic [NPIN-1:0] rd_mux;
    logic            rd_hit;

    assign dec = decode(addr);
    assign wsc = wr_data;

    genvar i;
    generate
        for (i = 0; i < NCTRL; i++) begin : g_ctrl
            logic hit;
            assign hit = wr_en && dec.word_ok && (dec.idx == (ADDR_W-2)'(i));
            gpb_setclr_reg #(.W(NPIN)) u_reg (
                .clk      (clk),
                .rst      (rst),
                .wr_hit   (hit),
                .set_bits (wsc.set),
                .clr_bits (wsc.clr),
                .q        (ctrl_q[i])
            );
        end
    endgenerate

    // write-one-to-clear uses only the low half
    always_comb begin
        rise_clr = '0;
        fall_clr = '0;
        if (wr_en && dec.word_ok && dec.idx == RI_RISE) rise_clr = wr_data[NPIN-1:0];
        if (wr_en && dec.word_ok && dec.idx == RI_FALL) fall_clr = wr_data[NPIN-1:0];
    end

    gpb_edge_unit #(.W(NPIN)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_in),
        .en_i     (ctrl_q[RI_IN_EN]),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .sample_o (sample),
        .rise_o   (rise_f),
        .fall_o   (fall_f)
    );

    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b0;
        if (dec.word_ok) begin
            rd_hit = 1'b1;
            case (dec.idx)
                RI_LEVEL, RI_DRV_EN, RI_IN_EN,
                RI_OALT_A, RI_OALT_B, RI_IALT: rd_mux = ctrl_q[dec.idx[2:0]];
                RI_RDBACK:                     rd_mux = ctrl_q[RI_LEVEL];
                RI_SAMPLE:                     rd_mux = sample;
                RI_RISE:                       rd_mux = rise_f;
                RI_FALL:                       rd_mux = fall_f;
                default:                       rd_hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= {{HALF{1'b0}}, {(HALF-NPIN){1'b0}}, rd_mux};
        end
    end

    assign pin_out = ctrl_q[RI_LEVEL];
    assign pin_oe  = ctrl_q[RI_DRV_EN];

    // R5: upper half of read data is always zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:HALF] == '0);

    // R11: a read that misses the map returns zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_hit) |=> (rd_data == '0));

    // R6: pin drivers only change on a write
    a_r6_pins_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/sim_gpio_bank_sc.sv
module sim_gpio_bank_sc;
    import gpb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   pin_out;
    logic [NPIN-1:0]   pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_bank_sc u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [15:0] e;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1'b0, 8'h00, 32'h0000_00F0, 16'h0000},  // R1 set
        '{1'b1, 8'h00, 32'h0,         16'h00F0},
        '{1'b0, 8'h00, 32'h0030_0001, 16'h0000},  // R2 clear, R3 keep
        '{1'b1, 8'h00, 32'h0,         16'h00C1},
        '{1'b0, 8'h00, 32'h0001_0001, 16'h0000},  // R4 clear wins
        '{1'b1, 8'h00, 32'h0,         16'h00C0},
        '{1'b0, 8'h04, 32'h0000_FFFF, 16'h0000},
        '{1'b0, 8'h04, 32'h8000_0000, 16'h0000},
        '{1'b1, 8'h04, 32'h0,         16'h7FFF},
        '{1'b0, 8'h0C, 32'h0000_00FF, 16'h0000},
        '{1'b0, 8'h10, 32'h0000_0F0F, 16'h0000},
        '{1'b0, 8'h14, 32'h0000_AAAA, 16'h0000},
        '{1'b1, 8'h0C, 32'h0,         16'h00FF},
        '{1'b0, 8'h0C, 32'h0002_0000, 16'h0000},  // claim pin 1
        '{1'b0, 8'h10, 32'h0002_0000, 16'h0000},
        '{1'b0, 8'h14, 32'h0002_0000, 16'h0000},
        '{1'b1, 8'h0C, 32'h0,         16'h00FD},
        '{1'b1, 8'h10, 32'h0,         16'h0F0D},
        '{1'b1, 8'h14, 32'h0,         16'hAAA8},
        '{1'b1, 8'h18, 32'h0,         16'h00C0},  // R6 read-back
        '{1'b0, 8'h08, 32'h0000_0003, 16'h0000},
        '{1'b1, 8'h08, 32'h0,         16'h0003}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, {16'h0, e});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R12 reset state
        chk("R12 pin_out", {16'h0, pin_out}, 32'h0);
        chk("R12 pin_oe",  {16'h0, pin_oe},  32'h0);
        rd_chk("R12 level", 8'h00, 16'h0);
        rd_chk("R12 rise",  8'h20, 16'h0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            if (VT[k].rd) begin
                rd(VT[k].a, v);
                chk($sformatf("R5 table vector %0d (R1/R2/R3/R4/R6)", k), v, {16'h0, VT[k].e});
            end else begin
                wr(VT[k].a, VT[k].d);
            end
        end

        // R6 pin vectors follow the registers
        chk("R6 pin_out", {16'h0, pin_out}, 32'h0000_00C0);
        chk("R6 pin_oe",  {16'h0, pin_oe},  32'h0000_7FFF);

        // R7 synchronizer depth: read sampled one edge after a change sees old value
        @(negedge clk);
        pin_in = 16'h0005; addr = 8'h1C; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7 not yet visible", rd_data, 32'h0);
        idle(3);
        rd_chk("R7 sample", 8'h1C, 16'h0005);

        // R8 rising: pin 0 enabled, pin 2 not
        rd_chk("R8 rise", 8'h20, 16'h0001);
        rd_chk("R9 no fall yet", 8'h24, 16'h0000);

        // R9 falling
        @(negedge clk) pin_in = 16'h0000;
        idle(4);
        rd_chk("R9 fall", 8'h24, 16'h0001);

        // R10 write-one-to-clear
        wr(8'h20, 32'hFFFF_0000);
        rd_chk("R10 high half ignored", 8'h20, 16'h0001);
        wr(8'h20, 32'h0000_0001);
        rd_chk("R10 rise cleared", 8'h20, 16'h0000);
        wr(8'h24, 32'h0000_0002);
        rd_chk("R10 zero bits keep", 8'h24, 16'h0001);
        wr(8'h24, 32'h0000_0001);
        rd_chk("R10 fall cleared", 8'h24, 16'h0000);

        // R11 unmapped, misaligned and read-only offsets
        wr(8'h28, 32'h0000_FFFF);
        rd_chk("R11 unmapped read", 8'h28, 16'h0);
        rd_chk("R11 misaligned read", 8'h02, 16'h0);
        wr(8'h01, 32'h0000_FFFF);
        wr(8'h18, 32'h0000_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R11 level untouched", 8'h00, 16'h00C0);
        rd_chk("R11 readback untouched", 8'h18, 16'h00C0);
        chk("R11 pin_out untouched", {16'h0, pin_out}, 32'h0000_00C0);

        // R12 reset mid-run
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        chk("R12 pin_out after reset", {16'h0, pin_out}, 32'h0);
        chk("R12 pin_oe after reset",  {16'h0, pin_oe},  32'h0);
        rd_chk("R12 in_en after reset", 8'h08, 16'h0);

        done = 1'b1;
        summary();
    end

endmodule